// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Splitter and Cycle Decoder

This block joins an 8-bit processor bus to its memory and peripheral devices. The processor sends the low address byte and the data byte over one shared 8-line lane, one after the other. It drives the high address byte on its own lines. A capture strobe marks the phase in which the shared lane holds address. While the strobe is high, the block passes the lane straight through as the low address byte. It also samples the lane on every clock edge of that phase. Once the strobe drops, the sampled byte is held, so the 16-bit address stays steady while the lane carries data.

A space-select input together with active-low read and write strobes picks one of four cycle kinds: memory read, memory write, port read and port write. The block flags an illegal state in which read and write are both low. It turns the shared lane toward the processor during a valid read. It also produces a chip-select for one memory window and one-hot selects for a set of peripheral port numbers.

The memory window and the port numbers are parameters. The select logic is purely combinational from the inputs and the held byte, so a device sees its select in the same cycle the bus presents the cycle.

Top module: `mux_bus_decoder`

## Requirements
- R1: `addr[15:8]` always equals `addrHi`. While `ale` is 1, `addr[7:0]` equals `adIn` in the same cycle.
- R2: At each rising clock edge where `ale` is 1, the low byte is taken from `adIn`. While `ale` is 0, `addr[7:0]` keeps the last byte taken, whatever `adIn` does.
- R3: Cycle decode, with at most one of the four strobes high:
  - `memRd` = (`ioSel`=0, `rdN`=0, `wrN`=1)
  - `memWr` = (`ioSel`=0, `wrN`=0, `rdN`=1)
  - `ioRd` = (`ioSel`=1, `rdN`=0, `wrN`=1)
  - `ioWr` = (`ioSel`=1, `wrN`=0, `rdN`=1)
- R4: When `rdN` and `wrN` are both 0, `busErr` is 1. In that state the four cycle strobes, `memCs` and every `portSel` bit are 0. In all other states `busErr` is 0.
- R5: `adOe` is 1 exactly when `rdN`=0, `wrN`=1 and `ale`=0. `adOut` equals `devData` when `adOe` is 1 and 00H otherwise.
- R6: `memCs` is 1 exactly when `ioSel`=0, there is no bus error, and MEM_BASE <= `addr` < MEM_BASE+MEM_SIZE. The defaults are 8000H and 256, so 8000H–80FFH select and 7FFFH and 8100H do not.
- R7: `portSel[i]` is 1 exactly when `ioSel`=1, there is no bus error, and `addr[7:0]` equals port number i. With the defaults, bits 0..3 match ports 01H, 02H, 21H and 40H. No bit is set in a memory-space cycle.
- R8: While `rstN` is 0, and after reset until the next capture, the held low byte is 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| adIn | input | 8 | Shared lane as seen from the processor side |
| addrHi | input | 8 | Dedicated high address byte |
| ale | input | 1 | Address capture strobe, active high |
| ioSel | input | 1 | Space select: 1 = port space, 0 = memory space |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| devData | input | 8 | Read data returned by the selected device |
| addr | output | 16 | Demultiplexed full address |
| memRd | output | 1 | Memory read cycle |
| memWr | output | 1 | Memory write cycle |
| ioRd | output | 1 | Port read cycle |
| ioWr | output | 1 | Port write cycle |
| busErr | output | 1 | Read and write low together |
| adOe | output | 1 | Enable for driving the shared lane toward the processor |
| adOut | output | 8 | Data driven onto the shared lane |
| memCs | output | 1 | Memory window chip-select |
| portSel | output | 4 | One-hot peripheral port selects |

## Verification
The one stored value here is the held low address byte. If it is wrong, `addr[7:0]` is wrong in the first cycle after the strobe drops. From that same cycle, `memCs` and `portSel` answer for the wrong device. A faulty decode shows as the wrong strobe, or as two strobes high, in the very cycle the inputs change. The reference model is checked against every output on every clock, so a fault surfaces within one cycle of the stimulus that exposes it. The stimulus includes the window edges, unlisted ports and lane changes while the strobe is low.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;

  // Qualified cycle kinds, one per decoded transfer type
  typedef struct packed {
    logic memRd;
    logic memWr;
    logic ioRd;
    logic ioWr;
    logic busErr;
  } cycle_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic memSpace;   // memory space, no error
    logic ioSpace;    // port space, no error
    logic driveRead;  // turn the lane toward the processor
  } dp_ctrl_t;

endpackage

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mux_bus_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     ale,
  input  logic     ioSel,
  input  logic     rdN,
  input  logic     wrN,
  output cycle_t   cyc,
  output dp_ctrl_t dpCtl
);

  logic rdAct, wrAct, clash;

  assign rdAct = ~rdN;
  assign wrAct = ~wrN;
  assign clash = rdAct & wrAct;

  always_comb begin
    cyc        = '0;
    cyc.busErr = clash;
    if (!clash) begin
      cyc.memRd = ~ioSel & rdAct;
      cyc.memWr = ~ioSel & wrAct;
      cyc.ioRd  =  ioSel & rdAct;
      cyc.ioWr  =  ioSel & wrAct;
    end
  end

  always_comb begin
    dpCtl.memSpace  = ~ioSel & ~clash;
    dpCtl.ioSpace   =  ioSel & ~clash;
    dpCtl.driveRead = rdAct & ~wrAct & ~ale;
  end

  // R3: the four cycle kinds never overlap
  p_one_cycle_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cyc.memRd, cyc.memWr, cyc.ioRd, cyc.ioWr}));

  // R4: an error cycle raises no transfer strobe and opens no space
  p_err_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    cyc.busErr |-> !(cyc.memRd | cyc.memWr | cyc.ioRd | cyc.ioWr |
                     dpCtl.memSpace | dpCtl.ioSpace));

  // R5: the lane is only turned around during a read strobe
  p_drive_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.driveRead |-> (cyc.memRd | cyc.ioRd));

endmodule

// File: rtl/mux_bus_dp.sv
module mux_bus_dp
  import mux_bus_pkg::*;
#(
  parameter int unsigned          DATA_W    = 8,
  parameter int unsigned          HI_W      = 8,
  parameter int unsigned          N_PORTS   = 4,
  parameter logic [DATA_W+HI_W-1:0] MEM_BASE = 16'h8000,
  parameter int unsigned          MEM_SIZE  = 256,
  parameter logic [N_PORTS*DATA_W-1:0] PORT_NUMS = 32'h40_21_02_01
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ale,
  input  logic [DATA_W-1:0]       adIn,
  input  logic [HI_W-1:0]         addrHi,
  input  logic [DATA_W-1:0]       devData,
  input  dp_ctrl_t                dpCtl,
  output logic [DATA_W+HI_W-1:0]  addr,
  output logic                    adOe,
  output logic [DATA_W-1:0]       adOut,
  output logic                    memCs,
  output logic [N_PORTS-1:0]      portSel
);

  localparam int unsigned ADDR_W = DATA_W + HI_W;
  localparam int unsigned CMP_W  = ADDR_W + 1;
  localparam logic [CMP_W-1:0] WIN_LO = CMP_W'(MEM_BASE);
  localparam logic [CMP_W-1:0] WIN_HI = CMP_W'(MEM_BASE) + CMP_W'(MEM_SIZE);

  logic [DATA_W-1:0] lowHold;
  logic [DATA_W-1:0] addrLo;
  logic [CMP_W-1:0]  addrWide;
  logic              inWindow;

  // Held low byte: sampled while the capture strobe is high
  always_ff @(posedge clk) begin
    if (!rstN)    lowHold <= '0;
    else if (ale) lowHold <= adIn;
  end

  assign addrLo   = ale ? adIn : lowHold;
  assign addr     = {addrHi, addrLo};
  assign addrWide = {1'b0, addr};
  assign inWindow = (addrWide >= WIN_LO) && (addrWide < WIN_HI);
  assign memCs    = dpCtl.memSpace & inWindow;

  assign adOe  = dpCtl.driveRead;
  assign adOut = dpCtl.driveRead ? devData : '0;

  for (genvar i = 0; i < N_PORTS; i++) begin : g_port
    assign portSel[i] = dpCtl.ioSpace &&
                        (addrLo == PORT_NUMS[i*DATA_W +: DATA_W]);
  end

  // R2: with the strobe low across two edges the low byte holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!ale) && !ale) |-> $stable(addrLo));

  // R5: a closed lane carries nothing
  p_idle_lane_r5: assert property (@(posedge clk) disable iff (!rstN)
    !adOe |-> (adOut == '0));

  // R6: chip-select never fires outside memory space
  p_memcs_space_r6: assert property (@(posedge clk) disable iff (!rstN)
    memCs |-> !dpCtl.ioSpace);

  // R7: distinct port numbers give at most one select
  p_port_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(portSel) && !(memCs && (portSel != '0)));

endmodule

// File: rtl/mux_bus_decoder.sv
module mux_bus_decoder
  import mux_bus_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned HI_W     = 8,
  parameter int unsigned N_PORTS  = 4,
  parameter logic [DATA_W+HI_W-1:0] MEM_BASE = 16'h8000,
  parameter int unsigned MEM_SIZE = 256,
  parameter logic [N_PORTS*DATA_W-1:0] PORT_NUMS = 32'h40_21_02_01
)(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [DATA_W-1:0]       adIn,
  input  logic [HI_W-1:0]         addrHi,
  input  logic                    ale,
  input  logic                    ioSel,
  input  logic                    rdN,
  input  logic                    wrN,
  input  logic [DATA_W-1:0]       devData,
  output logic [DATA_W+HI_W-1:0]  addr,
  output logic                    memRd,
  output logic                    memWr,
  output logic                    ioRd,
  output logic                    ioWr,
  output logic                    busErr,
  output logic                    adOe,
  output logic [DATA_W-1:0]       adOut,
  output logic                    memCs,
  output logic [N_PORTS-1:0]      portSel
);

  cycle_t   cyc;
  dp_ctrl_t dpCtl;

  mux_bus_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .ale   (ale),
    .ioSel (ioSel),
    .rdN   (rdN),
    .wrN   (wrN),
    .cyc   (cyc),
    .dpCtl (dpCtl)
  );

  mux_bus_dp #(
    .DATA_W    (DATA_W),
    .HI_W      (HI_W),
    .N_PORTS   (N_PORTS),
    .MEM_BASE  (MEM_BASE),
    .MEM_SIZE  (MEM_SIZE),
    .PORT_NUMS (PORT_NUMS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ale     (ale),
    .adIn    (adIn),
    .addrHi  (addrHi),
    .devData (devData),
    .dpCtl   (dpCtl),
    .addr    (addr),
    .adOe    (adOe),
    .adOut   (adOut),
    .memCs   (memCs),
    .portSel (portSel)
  );

  assign memRd  = cyc.memRd;
  assign memWr  = cyc.memWr;
  assign ioRd   = cyc.ioRd;
  assign ioWr   = cyc.ioWr;
  assign busErr = cyc.busErr;

  // R4: an error cycle selects no device at all
  p_err_nosel_r4: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (!memCs && (portSel == '0) && !adOe));

endmodule

// File: tb/mux_bus_decoder_test.sv
`timescale 1ns/1ps
module mux_bus_decoder_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  adIn = 8'h00, addrHi = 8'h00, devData = 8'h00;
  logic        ale = 1'b0, ioSel = 1'b0, rdN = 1'b1, wrN = 1'b1;
  logic [15:0] addr;
  logic        memRd, memWr, ioRd, ioWr, busErr, adOe, memCs;
  logic [7:0]  adOut;
  logic [3:0]  portSel;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit closed = 1'b0;
  logic [7:0] refLow = 8'h00;

  always #4 clk = ~clk;   // 125 MHz

  mux_bus_decoder uut (
    .clk(clk), .rstN(rstN), .adIn(adIn), .addrHi(addrHi), .ale(ale),
    .ioSel(ioSel), .rdN(rdN), .wrN(wrN), .devData(devData),
    .addr(addr), .memRd(memRd), .memWr(memWr), .ioRd(ioRd), .ioWr(ioWr),
    .busErr(busErr), .adOe(adOe), .adOut(adOut), .memCs(memCs),
    .portSel(portSel)
  );

  // Reference: the held byte, sampled on rising edges while the strobe is high
  always @(posedge clk) begin
    if (!rstN)    refLow <= 8'h00;
    else if (ale) refLow <= adIn;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Full per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (!closed) begin
      logic [7:0]  eLo;
      logic [15:0] eAddr;
      logic        eErr, eOe;
      logic [3:0]  ePort;
      eLo   = ale ? adIn : refLow;
      eAddr = {addrHi, eLo};
      eErr  = !rdN && !wrN;
      eOe   = !rdN && wrN && !ale;
      case (eLo)
        8'h01:   ePort = 4'b0001;
        8'h02:   ePort = 4'b0010;
        8'h21:   ePort = 4'b0100;
        8'h40:   ePort = 4'b1000;
        default: ePort = 4'b0000;
      endcase
      if (!ioSel || eErr) ePort = 4'b0000;
      chk("R1/R2 addr", addr, eAddr);
      chk("R3 memRd", 16'(memRd), 16'(!ioSel && !rdN && wrN));
      chk("R3 memWr", 16'(memWr), 16'(!ioSel && !wrN && rdN));
      chk("R3 ioRd",  16'(ioRd),  16'(ioSel && !rdN && wrN));
      chk("R3 ioWr",  16'(ioWr),  16'(ioSel && !wrN && rdN));
      chk("R4 busErr", 16'(busErr), 16'(eErr));
      chk("R5 adOe", 16'(adOe), 16'(eOe));
      chk("R5 adOut", 16'(adOut), eOe ? 16'(devData) : 16'h0);
      chk("R6 memCs", 16'(memCs),
          16'(!ioSel && !eErr && eAddr >= 16'h8000 && eAddr <= 16'h80FF));
      chk("R7 portSel", 16'(portSel), 16'(ePort));
    end
  end

  task automatic drive(input logic a, input logic [7:0] ad, input logic [7:0] hi,
                       input logic io, input logic r, input logic w,
                       input logic [7:0] dd);
    @(posedge clk);
    #2;
    ale = a; adIn = ad; addrHi = hi; ioSel = io; rdN = r; wrN = w; devData = dd;
  endtask

  // Address phase then strobe phase; lane carries data in the second
  task automatic busCycle(input logic [15:0] a, input logic io, input logic r,
                          input logic w, input logic [7:0] lane, input logic [7:0] dd);
    drive(1'b1, a[7:0], a[15:8], io, 1'b1, 1'b1, 8'h00);
    drive(1'b0, lane, a[15:8], io, r, w, dd);
    @(negedge clk);
  endtask

  task automatic summary;
    closed = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // R8: held byte cleared during reset
    @(negedge clk);
    chk("R8 reset low byte", 16'(addr[7:0]), 16'h00);
    drive(1'b0, 8'h5A, 8'h12, 1'b0, 1'b1, 1'b1, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    chk("R8 after reset", addr, 16'h1200);
    chk("R3 idle strobes", 16'({memRd, memWr, ioRd, ioWr}), 16'h0);

    // R1: transparent while strobe high
    drive(1'b1, 8'h77, 8'h80, 1'b0, 1'b1, 1'b1, 8'h00);
    @(negedge clk);
    chk("R1 transparent", addr, 16'h8077);

    // Memory read inside the window
    busCycle(16'h8005, 1'b0, 1'b0, 1'b1, 8'h3C, 8'hA5);
    chk("R2 held addr", addr, 16'h8005);
    chk("R3 memRd", 16'(memRd), 16'h1);
    chk("R5 adOut", 16'(adOut), 16'h00A5);
    chk("R6 memCs in", 16'(memCs), 16'h1);
    // R2: lane changes while strobe low do not move the address
    drive(1'b0, 8'hC3, 8'h80, 1'b0, 1'b0, 1'b1, 8'h5A);
    @(negedge clk);
    chk("R2 ignore lane", addr, 16'h8005);

    // Window edges
    busCycle(16'h80FF, 1'b0, 1'b1, 1'b0, 8'h11, 8'h00);
    chk("R6 top edge in", 16'(memCs), 16'h1);
    chk("R3 memWr", 16'(memWr), 16'h1);
    chk("R5 no drive on write", 16'(adOe), 16'h0);
    busCycle(16'h8100, 1'b0, 1'b0, 1'b1, 8'h22, 8'h33);
    chk("R6 above window", 16'(memCs), 16'h0);
    busCycle(16'h7FFF, 1'b0, 1'b0, 1'b1, 8'h22, 8'h33);
    chk("R6 below window", 16'(memCs), 16'h0);

    // Port cycles
    busCycle(16'h0021, 1'b1, 1'b0, 1'b1, 8'h99, 8'h5E);
    chk("R7 port 21", 16'(portSel), 16'h4);
    chk("R3 ioRd", 16'(ioRd), 16'h1);
    busCycle(16'h0040, 1'b1, 1'b1, 1'b0, 8'h99, 8'h00);
    chk("R7 port 40", 16'(portSel), 16'h8);
    chk("R3 ioWr", 16'(ioWr), 16'h1);
    busCycle(16'h0033, 1'b1, 1'b0, 1'b1, 8'h01, 8'h00);
    chk("R7 unlisted port", 16'(portSel), 16'h0);
    busCycle(16'h8001, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
    chk("R7 memory space no port", 16'(portSel), 16'h0);

    // R4: clash suppresses every select
    busCycle(16'h0002, 1'b1, 1'b0, 1'b0, 8'h00, 8'hFF);
    chk("R4 err port", 16'({busErr, portSel, adOe}), 16'h20);
    busCycle(16'h8000, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF);
    chk("R4 err mem", 16'({busErr, memCs, memRd, memWr}), 16'h8);

    // R5: read held during the address phase does not drive
    drive(1'b1, 8'h01, 8'h00, 1'b1, 1'b0, 1'b1, 8'h44);
    @(negedge clk);
    chk("R5 no drive with ale", 16'(adOe), 16'h0);

    // Random traffic, compared every cycle by the reference
    for (int i = 0; i < 400; i++) begin
      logic [7:0] pick;
      pick = 8'($urandom_range(0, 5));
      drive(1'($urandom), (pick < 4) ? (pick == 0 ? 8'h01 : pick == 1 ? 8'h21 :
            pick == 2 ? 8'h40 : 8'h02) : 8'($urandom),
            (pick == 5) ? 8'h80 : 8'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 8'($urandom));
    end
    @(negedge clk);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
    end
  end

endmodule